// File: doc/BRIEF.md
# Borrowed Memory Bus Requester

This block sits inside a secondary bus master that has to borrow an external memory bus from a primary master to reach one shared chip-select region. When the local core asks for an access, the block raises a bus-request line and watches the grant line on every falling clock edge. Once it sees the grant, it opens the access window on the following rising edge. When the memory side signals completion, it gives the bus back. If the shared region is synchronous DRAM, it first waits out an auto-precharge interval.

The block also drives the enable for the address/control buffer that joins the two buses. It provides a release output, which is the request line delayed by one clock. Board logic can use this output to keep a slow buffer from overlapping the primary master's next cycle. The primary master may take the grant away while the secondary master still holds the bus, for example to run a refresh. Ownership therefore follows the request line, never the grant line. The block also publishes the CAS latency that reads of the shared synchronous DRAM must be programmed with. This value is two above the device value, because the buffer adds one cycle on the way out and one cycle on the way back.

Top module: `shared_bus_borrower`

## Requirements
- R1: A high `rst` sampled at a falling edge clears `busReq`, `bufEn` and `busRel`, and returns the controller to idle. A high `rst` at a rising edge clears `accActive`.
- R2: In idle, a high `accReq` sampled at a falling edge sets `busReq` on that edge. A high `grantIn` without a pending request changes no output.
- R3: While requesting, a high `grantIn` sampled at a falling edge makes `accActive` rise on the next rising edge. A low `grantIn` keeps the block waiting, with `busReq` held high and `accActive` low.
- R4: Once the grant has been seen, dropping `grantIn` does not end ownership. `busReq`, `bufEn` and `accActive` stay high until `accDone` is sampled.
- R5: `bufEn` turns on at the falling edge where the grant is detected. It stays on while `busReq` is high and turns off at the same falling edge where `busReq` falls.
- R6: `busRel` equals the value `busReq` had one clock earlier, updated on falling edges.
- R7: With `regionSdram` low, an `accDone` sampled high at a falling edge during an access drops `busReq` and `bufEn` on that same edge. `accActive` falls at the next rising edge.
- R8: With `regionSdram` high, an `accDone` sampled during an access ends `accActive` at the next rising edge. `busReq` and `bufEn` then stay high for `PRECHG_CYC` (default 2) further falling edges and fall on the last of them.
- R9: `casLatProg` equals the device CAS latency parameter `DEV_CAS_LAT` plus 2. The default device latency of 2 gives 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Request and grant are handled on the falling edge, and the access start on the rising edge |
| rst | input | 1 | Active-high synchronous reset |
| accReq | input | 1 | Local core wants an access to the shared region |
| accDone | input | 1 | Memory access to the shared region has completed |
| grantIn | input | 1 | Bus grant from the primary master, active high |
| regionSdram | input | 1 | High when the shared region holds synchronous DRAM |
| busReq | output | 1 | Bus request to the primary master, active high |
| bufEn | output | 1 | Enable for the address/control bridge buffer |
| busRel | output | 1 | Request delayed by one clock, for buffer turn-off control |
| accActive | output | 1 | Access window open on the borrowed bus |
| casLatProg | output | CAS_W | CAS latency to program for shared synchronous DRAM reads |

## Verification
A wrong controller state shows up at the ports within one falling edge. A missed grant leaves `busReq` high with `accActive` still low at the next rising edge. An early release drops `busReq` and `bufEn` while the precharge wait should still hold them. `busRel` repeats every such error one clock later. This gives each fault a second observation point, which tells a state error apart from a delay-path error. A precharge count that is off by one moves the falling edge of `busReq` by exactly one clock relative to the sampled `accDone`, so the bench samples every clock around that window.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_OWN   = 2'd2,
    ST_PRECH = 2'd3
  } sbbState_t;

  typedef struct packed {
    logic reqSet;
    logic reqClr;
    logic bufSet;
    logic bufClr;
    logic cntLoad;
    logic cntDec;
    logic owning;
  } sbbStrobe_t;

endpackage

// File: rtl/sbb_ctrl.sv
module sbb_ctrl
  import sbb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accReq,
  input  logic       accDone,
  input  logic       grantIn,
  input  logic       regionSdram,
  input  logic       cntZero,
  output sbbStrobe_t strobe
);

  sbbState_t curState;
  sbbState_t nxtState;

  // Request and grant decisions are made on the falling edge
  always_ff @(negedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    strobe   = '0;
    strobe.owning = (curState == ST_OWN);
    unique case (curState)
      ST_IDLE: begin
        if (accReq) begin
          strobe.reqSet = 1'b1;
          nxtState      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        // without a fresh grant the request simply stays up
        if (grantIn) begin
          strobe.bufSet = 1'b1;
          nxtState      = ST_OWN;
        end
      end
      ST_OWN: begin
        // grant line ignored here: ownership follows the request line
        if (accDone) begin
          if (regionSdram) begin
            strobe.cntLoad = 1'b1;
            nxtState       = ST_PRECH;
          end else begin
            strobe.reqClr = 1'b1;
            strobe.bufClr = 1'b1;
            nxtState      = ST_IDLE;
          end
        end
      end
      ST_PRECH: begin
        if (cntZero) begin
          strobe.reqClr = 1'b1;
          strobe.bufClr = 1'b1;
          nxtState      = ST_IDLE;
        end else begin
          strobe.cntDec = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sbb_dpath.sv
module sbb_dpath
  import sbb_pkg::*;
#(
  parameter int PRECHG_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  sbbStrobe_t strobe,
  output logic       cntZero,
  output logic       busReq,
  output logic       bufEn,
  output logic       busRel,
  output logic       accActive
);

  localparam int CNT_W = $clog2(PRECHG_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(PRECHG_CYC - 1);

  logic [CNT_W-1:0] preCnt;

  // falling-edge registers: request, buffer, release, precharge count
  always_ff @(negedge clk) begin
    if (rst) begin
      busReq <= 1'b0;
      bufEn  <= 1'b0;
      busRel <= 1'b0;
      preCnt <= '0;
    end else begin
      busRel <= busReq;
      if (strobe.reqSet)      busReq <= 1'b1;
      else if (strobe.reqClr) busReq <= 1'b0;
      if (strobe.bufSet)      bufEn <= 1'b1;
      else if (strobe.bufClr) bufEn <= 1'b0;
      if (strobe.cntLoad)     preCnt <= CNT_START;
      else if (strobe.cntDec) preCnt <= preCnt - 1'b1;
    end
  end

  assign cntZero = (preCnt == '0);

  // the access window opens on the rising edge after the grant edge
  always_ff @(posedge clk) begin
    if (rst) accActive <= 1'b0;
    else     accActive <= strobe.owning;
  end

endmodule

// File: rtl/shared_bus_borrower.sv
module shared_bus_borrower
  import sbb_pkg::*;
#(
  parameter int PRECHG_CYC  = 2,
  parameter int DEV_CAS_LAT = 2,
  parameter int CAS_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accReq,
  input  logic             accDone,
  input  logic             grantIn,
  input  logic             regionSdram,
  output logic             busReq,
  output logic             bufEn,
  output logic             busRel,
  output logic             accActive,
  output logic [CAS_W-1:0] casLatProg
);

  // one cycle out through the buffer, one cycle back
  localparam int BUF_EXTRA = 2;
  localparam logic [CAS_W-1:0] CAS_PROG = CAS_W'(DEV_CAS_LAT + BUF_EXTRA);

  sbbStrobe_t strobe;
  logic       cntZero;

  sbb_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .accReq      (accReq),
    .accDone     (accDone),
    .grantIn     (grantIn),
    .regionSdram (regionSdram),
    .cntZero     (cntZero),
    .strobe      (strobe)
  );

  sbb_dpath #(.PRECHG_CYC(PRECHG_CYC)) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cntZero   (cntZero),
    .busReq    (busReq),
    .bufEn     (bufEn),
    .busRel    (busRel),
    .accActive (accActive)
  );

  assign casLatProg = CAS_PROG;

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker (
  input logic clk,
  input logic rst,
  input logic accReq,
  input logic grantIn,
  input logic busReq,
  input logic bufEn,
  input logic busRel,
  input logic accActive
);

  AST_REL_DELAY: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> (busRel == $past(busReq))); // R6

  AST_BUF_NEEDS_REQ: assert property (@(negedge clk) disable iff (rst)
    bufEn |-> busReq); // R5

  AST_BUF_ON_GRANT: assert property (@(negedge clk) disable iff (rst)
    $rose(bufEn) |-> ($past(grantIn) && $past(busReq))); // R5

  AST_REQ_FROM_CORE: assert property (@(negedge clk) disable iff (rst)
    $rose(busReq) |-> $past(accReq)); // R2

  AST_ACT_HAS_BUF: assert property (@(negedge clk) disable iff (rst)
    accActive |-> bufEn); // R4

endmodule

bind shared_bus_borrower sbb_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .accReq    (accReq),
  .grantIn   (grantIn),
  .busReq    (busReq),
  .bufEn     (bufEn),
  .busRel    (busRel),
  .accActive (accActive)
);

// File: tb/shared_bus_borrower_tb.sv
module shared_bus_borrower_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accReq = 1'b0;
  logic accDone = 1'b0;
  logic grantIn = 1'b0;
  logic regionSdram = 1'b0;
  logic busReq, bufEn, busRel, accActive;
  logic [3:0] casLatProg;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shared_bus_borrower dut_i (
    .clk         (clk),
    .rst         (rst),
    .accReq      (accReq),
    .accDone     (accDone),
    .grantIn     (grantIn),
    .regionSdram (regionSdram),
    .busReq      (busReq),
    .bufEn       (bufEn),
    .busRel      (busRel),
    .accActive   (accActive),
    .casLatProg  (casLatProg)
  );

  // {sdram, accReq, grant, done, expReq, expBuf, expRel, expAct, tag}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b0000_0000_0010, // R2 idle
    12'b0010_0000_0010, // R2 grant without request ignored
    12'b1100_1000_0010, // R2 request raised
    12'b1100_1010_0011, // R3 no grant yet, keep waiting
    12'b1110_1111_0011, // R3 grant seen, access opens
    12'b1000_1111_0100, // R4 grant withdrawn, still owned
    12'b1000_1111_0100, // R4
    12'b1001_1110_1000, // R8 done, precharge wait begins
    12'b1000_1110_1000, // R8 still waiting
    12'b1000_0010_1000, // R8 released after PRECHG_CYC edges
    12'b0000_0000_0110, // R6 release follows request
    12'b0100_1000_0010, // R2 second request
    12'b0110_1111_0011, // R3
    12'b0001_0010_0111, // R7 non-SDRAM releases at once
    12'b0000_0000_0110  // R6
  };

  task automatic check(input int tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: {req,buf,rel,act} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check(1, {busReq, bufEn, busRel, accActive}, 4'b0000); // R1 reset state
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      {regionSdram, accReq, grantIn, accDone} = VEC[i][11:8];
      step();
      check(int'(VEC[i][3:0]), {busReq, bufEn, busRel, accActive}, VEC[i][7:4]);
    end

    // R1: reset in the middle of an owned access
    {regionSdram, accReq, grantIn, accDone} = 4'b1110;
    step();
    step();
    check(3, {busReq, bufEn, busRel, accActive}, 4'b1111);
    rst = 1'b1;
    step();
    check(1, {busReq, bufEn, busRel, accActive}, 4'b0000);
    {regionSdram, accReq, grantIn, accDone} = 4'b0000;
    rst = 1'b0;
    step();
    check(1, {busReq, bufEn, busRel, accActive}, 4'b0000);

    // R9: programmed CAS latency = device latency 2 + 2
    checks++;
    if (casLatProg !== 4'd4) begin
      errors++;
      $display("FAIL R9: casLatProg got %0d expected 4", casLatProg);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule